// File: doc/BRIEF.md
# Hashed Page-Table Group Search

This block takes a virtual address and looks for its translation in a hashed page table kept in memory. From the address and the page-size settings it forms a group hash for a 256 MB segment. It also forms the tag word that a matching entry's first doubleword must carry. It then walks the entries of the selected group through a synchronous read port with one cycle of latency.

The search is started by a one-cycle `start_i` pulse. Slots are probed from 0 upward and the first matching slot wins. If the primary group has no match, the walk repeats on the group chosen by the bitwise complement of the hash. When a match is found the block fetches that entry's second doubleword and reports it together with the slot number and the pass that found it. If neither group matches, the block reports a miss.

The control is a five-state machine. `ST_IDLE` waits for a start. `ST_LAUNCH` issues the first tag read. `ST_PROBE` judges one returned tag word per cycle and either issues the next tag read, switches to the secondary group, issues the read of the second word, or gives up. `ST_FETCH_R` captures the second word. `ST_REPORT` pulses `done_o`. The transitions are:

| From | To | Condition |
|---|---|---|
| `ST_IDLE` | `ST_LAUNCH` | start |
| `ST_LAUNCH` | `ST_PROBE` | always |
| `ST_PROBE` | `ST_FETCH_R` | match |
| `ST_PROBE` | `ST_PROBE` | no match and another slot or the secondary pass remains |
| `ST_PROBE` | `ST_REPORT` | miss on slot 7 of the secondary pass |
| `ST_FETCH_R` | `ST_REPORT` | always |
| `ST_REPORT` | `ST_LAUNCH` | start |
| `ST_REPORT` | `ST_IDLE` | no start |

Top module: `hpt_group_search`

## Requirements
- R1: After reset, `busy_o`, `done_o`, `rd_en_o` and `hit_o` are 0, and no read is issued while the block is not busy.
- R2: The primary hash is (VA bits 63:28, zero-extended to 39 bits) XOR ((VA AND 0x0FFFFFFF) >> `pshift_i`). The first read of a search is at byte address ((hash AND `tbl_mask_i`) << 7).
- R3: Within a group, slot s has its tag word at byte offset 16·s and its second word at 16·s+8. Tag words are read in ascending slot order, one per cycle. Once the second word has been requested, no further read follows.
- R4: `cmp_word_o` equals (((VA >> 23) AND NOT `avpn_mask_i`) << 7), with bit 2 set exactly when `psize_i` is nonzero (0 means the 4 KB size).
- R5: A slot matches only when bit 0 (valid) of its tag word is set and the tag word XOR `cmp_word_o` is zero under mask 0x3FFFFFFFFFFFFF80. Bits 63:62 and 6:0 are otherwise ignored.
- R6: When several slots of a group match, the lowest-numbered one is reported.
- R7: After a primary miss, the secondary pass reads the group ((NOT hash) AND `tbl_mask_i`) starting at slot 0. Bit 1 of a tag word must be 1 to match in the secondary pass and 0 in the primary pass.
- R8: On a hit, `hit_o`=1, `slot_o` is the slot, `sec_o` is the pass (1 = secondary) and `rword_o` is the slot's second word. A miss on both groups gives `hit_o`=0 after exactly 16 tag reads. Results change only in a cycle where `done_o` is high.
- R9: Counting clock edges after the edge that accepts start, `done_o` is first seen high after 3+8·p+k edges for a hit in slot k of pass p (0 primary, 1 secondary), and after 17 edges for a miss.
- R10: `start_i` has no effect while `busy_o` is high: the running search ends with its own results and timing.
- R11: `done_o` is high for exactly one cycle per search. A `start_i` in that cycle launches the next search at once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start pulse, accepted when not busy |
| va_i | input | 64 | Virtual address to translate |
| pshift_i | input | 6 | Page shift applied in the hash |
| avpn_mask_i | input | 64 | Bits cleared from VA>>23 when forming the tag |
| psize_i | input | 3 | Page-size index, 0 = 4 KB |
| tbl_mask_i | input | 39 | Group index mask of the table |
| rd_en_o | output | 1 | Memory read request |
| rd_addr_o | output | 46 | Byte address of the requested doubleword |
| rd_data_i | input | 64 | Read data, valid one cycle after the request |
| busy_o | output | 1 | Search in progress |
| done_o | output | 1 | One-cycle completion pulse |
| hit_o | output | 1 | Last search found a match |
| slot_o | output | 3 | Matching slot index |
| sec_o | output | 1 | Match came from the secondary pass |
| rword_o | output | 64 | Second doubleword of the matching entry |
| cmp_word_o | output | 64 | Tag word being compared against |

## Verification
Two functions share a cycle at two points. At slot 7 of the primary pass, the miss decision and the launch of the secondary group's first read happen in the same cycle. In the report cycle, the completion pulse and the acceptance of the next start happen together.

The sweep places the winning slot in every position of both passes. This drives the pass switch right after a primary miss in slot 7 and checks the first secondary address and the exact edge count. Searches are also chained by holding start in the cycle where done is seen. The bench then checks that the earlier results were reported and that the following search runs to its own correct outcome.

// File: rtl/hpt_pkg.sv
package hpt_pkg;

    // Tag word fields and compare mask
    localparam logic [63:0] TAG_CMP_MASK = 64'h3FFF_FFFF_FFFF_FF80;
    localparam int          TB_VALID     = 0;
    localparam int          TB_SECOND    = 1;
    localparam int          TB_LARGE     = 2;
    localparam int          TAG_LSHIFT   = 7;
    localparam int          VA_TAG_RSH   = 23;

    // Bytes per doubleword, as a shift
    localparam int          DW_SHIFT     = 3;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_LAUNCH,
        ST_PROBE,
        ST_FETCH_R,
        ST_REPORT
    } scan_state_e;

endpackage

// File: rtl/hpt_group_hash.sv
module hpt_group_hash #(
    parameter int WORD_W    = 64,
    parameter int HASH_W    = 39,
    parameter int SEG_SHIFT = 28,
    parameter int SHIFT_W   = 6
) (
    input  logic [WORD_W-1:0]  va,
    input  logic [SHIFT_W-1:0] pshift,
    input  logic [HASH_W-1:0]  tbl_mask,
    input  logic               second,
    output logic [HASH_W-1:0]  group
);
    localparam logic [WORD_W-1:0] SEG_LO_MASK = (WORD_W'(1) << SEG_SHIFT) - WORD_W'(1);

    logic [HASH_W-1:0] seg_part;
    logic [HASH_W-1:0] page_part;
    logic [HASH_W-1:0] hash;

    always_comb begin
        seg_part  = HASH_W'(va >> SEG_SHIFT);
        page_part = HASH_W'((va & SEG_LO_MASK) >> pshift);
        hash      = seg_part ^ page_part;
        group     = (second ? ~hash : hash) & tbl_mask;
    end

endmodule

// File: rtl/hpt_tag_build.sv
module hpt_tag_build #(
    parameter int WORD_W  = 64,
    parameter int PSIZE_W = 3
) (
    input  logic [WORD_W-1:0]  va,
    input  logic [WORD_W-1:0]  avpn_mask,
    input  logic [PSIZE_W-1:0] psize,
    output logic [WORD_W-1:0]  tag
);
    import hpt_pkg::*;

    logic [WORD_W-1:0] page_no;

    always_comb begin
        page_no       = (va >> VA_TAG_RSH) & ~avpn_mask;
        tag           = page_no << TAG_LSHIFT;
        tag[TB_LARGE] = (psize != '0);
    end

endmodule

// File: rtl/hpt_slot_cmp.sv
module hpt_slot_cmp #(
    parameter int WORD_W = 64
) (
    input  logic [WORD_W-1:0] entry_v,
    input  logic [WORD_W-1:0] tag,
    input  logic              second,
    output logic              match
);
    import hpt_pkg::*;

    logic tag_eq;
    logic pass_ok;

    always_comb begin
        tag_eq  = (((entry_v ^ tag) & WORD_W'(TAG_CMP_MASK)) == '0);
        pass_ok = (entry_v[TB_SECOND] == second);
        match   = entry_v[TB_VALID] && tag_eq && pass_ok;
    end

endmodule

// File: rtl/hpt_group_search.sv
module hpt_group_search #(
    parameter int WORD_W    = 64,
    parameter int HASH_W    = 39,
    parameter int SEG_SHIFT = 28,
    parameter int SHIFT_W   = 6,
    parameter int PSIZE_W   = 3,
    parameter int SLOT_W    = 3
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         start_i,
    input  logic [WORD_W-1:0]            va_i,
    input  logic [SHIFT_W-1:0]           pshift_i,
    input  logic [WORD_W-1:0]            avpn_mask_i,
    input  logic [PSIZE_W-1:0]           psize_i,
    input  logic [HASH_W-1:0]            tbl_mask_i,
    output logic                         rd_en_o,
    output logic [HASH_W+SLOT_W+3:0]     rd_addr_o,
    input  logic [WORD_W-1:0]            rd_data_i,
    output logic                         busy_o,
    output logic                         done_o,
    output logic                         hit_o,
    output logic [SLOT_W-1:0]            slot_o,
    output logic                         sec_o,
    output logic [WORD_W-1:0]            rword_o,
    output logic [WORD_W-1:0]            cmp_word_o
);
    import hpt_pkg::*;

    localparam int                ADDR_W    = HASH_W + SLOT_W + 4;
    localparam logic [SLOT_W-1:0] LAST_SLOT = '1;

    scan_state_e          state_q, state_d;
    logic [SLOT_W-1:0]    slot_q, slot_d;
    logic                 pass_q, pass_d;
    logic                 accept;

    logic [WORD_W-1:0]    va_q;
    logic [SHIFT_W-1:0]   pshift_q;
    logic [WORD_W-1:0]    avpn_q;
    logic [PSIZE_W-1:0]   psize_q;
    logic [HASH_W-1:0]    tmask_q;

    logic                 hit_q, sec_q;
    logic [SLOT_W-1:0]    rslot_q;
    logic [WORD_W-1:0]    rword_q;

    logic [WORD_W-1:0]    tag;
    logic                 slot_match;
    logic                 rd_pass;
    logic [SLOT_W-1:0]    rd_slot;
    logic                 rd_word;
    logic [HASH_W-1:0]    rd_group;

    // Sub-blocks
    hpt_tag_build #(.WORD_W(WORD_W), .PSIZE_W(PSIZE_W)) u_tag (
        .va        (va_q),
        .avpn_mask (avpn_q),
        .psize     (psize_q),
        .tag       (tag)
    );

    hpt_slot_cmp #(.WORD_W(WORD_W)) u_cmp (
        .entry_v (rd_data_i),
        .tag     (tag),
        .second  (pass_q),
        .match   (slot_match)
    );

    hpt_group_hash #(
        .WORD_W(WORD_W), .HASH_W(HASH_W), .SEG_SHIFT(SEG_SHIFT), .SHIFT_W(SHIFT_W)
    ) u_hash (
        .va       (va_q),
        .pshift   (pshift_q),
        .tbl_mask (tmask_q),
        .second   (rd_pass),
        .group    (rd_group)
    );

    assign accept = start_i && (state_q == ST_IDLE || state_q == ST_REPORT);

    // Next-state logic
    always_comb begin
        state_d = state_q;
        slot_d  = slot_q;
        pass_d  = pass_q;
        unique case (state_q)
            ST_IDLE: begin
                if (accept) begin
                    state_d = ST_LAUNCH;
                    slot_d  = '0;
                    pass_d  = 1'b0;
                end
            end
            ST_LAUNCH: begin
                state_d = ST_PROBE;
            end
            ST_PROBE: begin
                if (slot_match) begin
                    state_d = ST_FETCH_R;
                end else if (slot_q != LAST_SLOT) begin
                    slot_d = slot_q + SLOT_W'(1);
                end else if (!pass_q) begin
                    slot_d = '0;
                    pass_d = 1'b1;
                end else begin
                    state_d = ST_REPORT;
                end
            end
            ST_FETCH_R: begin
                state_d = ST_REPORT;
            end
            ST_REPORT: begin
                if (accept) begin
                    state_d = ST_LAUNCH;
                    slot_d  = '0;
                    pass_d  = 1'b0;
                end else begin
                    state_d = ST_IDLE;
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // State register, request capture and result registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q  <= ST_IDLE;
            slot_q   <= '0;
            pass_q   <= 1'b0;
            va_q     <= '0;
            pshift_q <= '0;
            avpn_q   <= '0;
            psize_q  <= '0;
            tmask_q  <= '0;
            hit_q    <= 1'b0;
            sec_q    <= 1'b0;
            rslot_q  <= '0;
            rword_q  <= '0;
        end else begin
            state_q <= state_d;
            slot_q  <= slot_d;
            pass_q  <= pass_d;
            if (accept) begin
                va_q     <= va_i;
                pshift_q <= pshift_i;
                avpn_q   <= avpn_mask_i;
                psize_q  <= psize_i;
                tmask_q  <= tbl_mask_i;
            end
            if (state_q == ST_FETCH_R) begin
                hit_q   <= 1'b1;
                sec_q   <= pass_q;
                rslot_q <= slot_q;
                rword_q <= rd_data_i;
            end else if (state_q == ST_PROBE && state_d == ST_REPORT) begin
                hit_q   <= 1'b0;
                sec_q   <= 1'b0;
                rslot_q <= '0;
                rword_q <= '0;
            end
        end
    end

    // Outputs
    always_comb begin
        rd_en_o = 1'b0;
        rd_pass = pass_q;
        rd_slot = slot_q;
        rd_word = 1'b0;
        unique case (state_q)
            ST_LAUNCH: begin
                rd_en_o = 1'b1;
                rd_pass = 1'b0;
                rd_slot = '0;
            end
            ST_PROBE: begin
                if (slot_match) begin
                    rd_en_o = 1'b1;
                    rd_word = 1'b1;
                end else if (slot_q != LAST_SLOT) begin
                    rd_en_o = 1'b1;
                    rd_slot = slot_q + SLOT_W'(1);
                end else if (!pass_q) begin
                    rd_en_o = 1'b1;
                    rd_pass = 1'b1;
                    rd_slot = '0;
                end
            end
            default: ;
        endcase
        rd_addr_o  = ADDR_W'({rd_group, rd_slot, rd_word, {DW_SHIFT{1'b0}}});
        busy_o     = (state_q == ST_LAUNCH) || (state_q == ST_PROBE) || (state_q == ST_FETCH_R);
        done_o     = (state_q == ST_REPORT);
        hit_o      = hit_q;
        sec_o      = sec_q;
        slot_o     = rslot_q;
        rword_o    = rword_q;
        cmp_word_o = tag;
    end

    // R1
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_o |-> !rd_en_o);

    // R3
    rword_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en_o && rd_addr_o[DW_SHIFT]) |=> !rd_en_o);

    // R11
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    // R10
    busy_done_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(busy_o && done_o));

    // R8
    result_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((hit_o != $past(hit_o)) || (rword_o != $past(rword_o))) |-> done_o);

    // R9
    launch_probe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_LAUNCH) |=> (state_q == ST_PROBE));

endmodule

// File: tb/hpt_group_search_bench.sv
`timescale 1ns/1ps
module hpt_group_search_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic [63:0] va_i = '0;
    logic [5:0]  pshift_i = '0;
    logic [63:0] avpn_mask_i = '0;
    logic [2:0]  psize_i = '0;
    logic [38:0] tbl_mask_i = 39'h7;
    logic        rd_en_o;
    logic [45:0] rd_addr_o;
    logic [63:0] rd_data_i = '0;
    logic        busy_o, done_o, hit_o, sec_o;
    logic [2:0]  slot_o;
    logic [63:0] rword_o, cmp_word_o;

    int n_tests = 0;
    int n_fail  = 0;
    int n_rd    = 0;
    logic [45:0] rd_log [32];
    logic [63:0] mem [128];

    always #4 clk = ~clk;

    hpt_group_search u_hpt_group_search (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .va_i(va_i),
        .pshift_i(pshift_i), .avpn_mask_i(avpn_mask_i), .psize_i(psize_i),
        .tbl_mask_i(tbl_mask_i), .rd_en_o(rd_en_o), .rd_addr_o(rd_addr_o),
        .rd_data_i(rd_data_i), .busy_o(busy_o), .done_o(done_o), .hit_o(hit_o),
        .slot_o(slot_o), .sec_o(sec_o), .rword_o(rword_o), .cmp_word_o(cmp_word_o)
    );

    always @(posedge clk) if (rd_en_o) rd_data_i <= mem[rd_addr_o[9:3]];

    always @(negedge clk) if (rd_en_o === 1'b1) begin
        if (n_rd < 32) rd_log[n_rd] = rd_addr_o;
        n_rd++;
    end

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    function automatic logic [38:0] ref_hash(input logic [63:0] va, input int sh);
        logic [63:0] hi, lo;
        hi = va >> 28;
        lo = (va & 64'h0FFF_FFFF) >> sh;
        return hi[38:0] ^ lo[38:0];
    endfunction

    function automatic logic [63:0] ref_tag(input logic [63:0] va, input logic [63:0] m, input int ps);
        logic [63:0] t;
        t = ((va >> 23) & ~m) << 7;
        if (ps != 0) t = t | 64'h4;
        return t;
    endfunction

    function automatic int midx(input int g, input int s, input int w);
        return g * 16 + s * 2 + w;
    endfunction

    task automatic clear_mem();
        for (int i = 0; i < 128; i++) mem[i] = '0;
    endtask

    // Launch from a negedge; return at the negedge where done is seen.
    task automatic run(input logic [63:0] va, input int sh, input logic [63:0] m,
                       input int ps, input int poke, output int cnt);
        va_i = va; pshift_i = 6'(sh); avpn_mask_i = m; psize_i = 3'(ps);
        start_i = 1'b1;
        n_rd = 0;
        @(posedge clk);
        @(negedge clk);
        start_i = 1'b0;
        cnt = 0;
        while (!done_o && cnt < 100) begin
            if (cnt == poke) begin
                start_i = 1'b1;
                va_i = va ^ 64'h0000_0100_0000_0000;
            end else begin
                start_i = 1'b0;
            end
            @(posedge clk);
            cnt++;
            @(negedge clk);
        end
        start_i = 1'b0;
        if (!done_o) check("watchdog", 64'(cnt), 64'hFFFF);
    endtask

    // Fill table: hit in slot k of pass p with decoys before it and later matches after it.
    task automatic build(input logic [63:0] va, input int sh, input logic [63:0] m,
                         input int ps, input int p, input int k, input logic [63:0] rpat);
        logic [38:0] h;
        logic [63:0] t;
        int gp, gs, g;
        logic [63:0] sec;
        clear_mem();
        h  = ref_hash(va, sh);
        gp = int'(h & 39'h7);
        gs = int'(~h & 39'h7);
        t  = ref_tag(va, m, ps) | 64'h1;
        sec = (p == 1) ? 64'h2 : 64'h0;
        g  = (p == 1) ? gs : gp;
        if (p == 1)
            for (int j = 0; j < 8; j++) mem[midx(gp, j, 0)] = t | 64'h2;
        for (int j = 0; j < k; j++) begin
            case (j % 3)
                0: mem[midx(g, j, 0)] = (t ^ 64'h80) | sec;
                1: mem[midx(g, j, 0)] = (t & ~64'h1) | sec;
                default: mem[midx(g, j, 0)] = (p == 1) ? t : (t | 64'h2);
            endcase
            mem[midx(g, j, 1)] = 64'hDEAD_0000 + 64'(j);
        end
        mem[midx(g, k, 0)] = t | sec | 64'hC000_0000_0000_0078;
        mem[midx(g, k, 1)] = rpat;
        for (int j = k + 1; j < 8; j++) begin
            mem[midx(g, j, 0)] = t | sec;
            mem[midx(g, j, 1)] = 64'hBAD0_0000 + 64'(j);
        end
    endtask

    initial begin
        #(200000 * 8);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        int cnt;
        int shs [3];
        logic [63:0] va, rpat, m;
        logic [38:0] h;
        int sh, ps, g;
        shs[0] = 12; shs[1] = 16; shs[2] = 24;
        clear_mem();
        repeat (3) @(negedge clk);
        // R1 reset state
        check("R1 busy", 64'(busy_o), 64'h0);
        check("R1 done", 64'(done_o), 64'h0);
        check("R1 rd_en", 64'(rd_en_o), 64'h0);
        check("R1 hit", 64'(hit_o), 64'h0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 idle no read", 64'(rd_en_o), 64'h0);

        // Sweep: every slot in both passes
        for (int p = 0; p < 2; p++) begin
            for (int k = 0; k < 8; k++) begin
                sh = shs[(p * 8 + k) % 3];
                ps = (sh == 12) ? 0 : ((sh == 16) ? 1 : 4);
                m  = (ps == 4) ? 64'h1 : 64'h0;
                va = 64'h0000_0A37_1234_5000 + 64'(k) * 64'h0000_0013_0D27_1000 + 64'(p) * 64'h0000_0201_7700_0000;
                rpat = 64'h1234_0000_0000_0000 | (64'(p) << 8) | 64'(k);
                build(va, sh, m, ps, p, k, rpat);
                run(va, sh, m, ps, -1, cnt);
                h = ref_hash(va, sh);
                check("R8 hit", 64'(hit_o), 64'h1);
                check("R6 slot", 64'(slot_o), 64'(k));
                check("R7 sec flag", 64'(sec_o), 64'(p));
                check("R8 rword", rword_o, rpat);
                check("R9 latency", 64'(cnt), 64'(3 + 8 * p + k));
                check("R4 cmp word", cmp_word_o, ref_tag(va, m, ps));
                check("R2 first addr", 64'(rd_log[0]), 64'(h & 39'h7) << 7);
                check("R3 read count", 64'(n_rd), 64'(8 * p + k + 2));
                g = (p == 1) ? int'(~h & 39'h7) : int'(h & 39'h7);
                check("R3 rword addr", 64'(rd_log[8 * p + k + 1]), (64'(g) << 7) | (64'(k) << 4) | 64'h8);
                if (k > 0) check("R3 step addr", 64'(rd_log[8 * p + k]), (64'(g) << 7) | (64'(k) << 4));
                if (p == 1) check("R7 second group addr", 64'(rd_log[8]), 64'(~h & 39'h7) << 7);
            end
        end

        // R11: done is one cycle, results hold afterwards
        @(negedge clk);
        check("R11 done low", 64'(done_o), 64'h0);
        check("R8 hold hit", 64'(hit_o), 64'h1);
        check("R8 hold rword", rword_o, 64'h1234_0000_0000_0107);

        // R8 R7: miss, every entry has the wrong secondary bit
        va = 64'h0000_0555_0ABC_D000;
        sh = 12;
        h = ref_hash(va, sh);
        clear_mem();
        for (int j = 0; j < 8; j++) begin
            mem[midx(int'(h & 39'h7), j, 0)]  = ref_tag(va, 0, 0) | 64'h3;
            mem[midx(int'(~h & 39'h7), j, 0)] = ref_tag(va, 0, 0) | 64'h1;
        end
        run(va, sh, 0, 0, -1, cnt);
        check("R8 miss hit", 64'(hit_o), 64'h0);
        check("R9 miss latency", 64'(cnt), 64'd17);
        check("R8 miss reads", 64'(n_rd), 64'd16);
        check("R7 miss second addr", 64'(rd_log[8]), 64'(~h & 39'h7) << 7);
        check("R3 miss last addr", 64'(rd_log[15]), (64'(~h & 39'h7) << 7) | 64'h70);

        // R10: start pulsed mid-search is ignored
        va = 64'h0000_0777_2468_0000;
        build(va, 16, 0, 1, 1, 3, 64'h5555_AAAA_0000_0001);
        run(va, 16, 0, 1, 2, cnt);
        check("R10 hit", 64'(hit_o), 64'h1);
        check("R10 slot", 64'(slot_o), 64'd3);
        check("R10 rword", rword_o, 64'h5555_AAAA_0000_0001);
        check("R10 latency", 64'(cnt), 64'd14);

        // R11: start in the done cycle, chained miss then hit
        clear_mem();
        run(64'h0000_0123_0000_0000, 12, 0, 0, -1, cnt);
        check("R11 first miss", 64'(hit_o), 64'h0);
        va = 64'h0000_0ABC_0F0F_0000;
        build(va, 24, 64'h1, 4, 0, 5, 64'h0F0F_0000_0000_0123);
        run(va, 24, 64'h1, 4, -1, cnt);
        check("R11 chained hit", 64'(hit_o), 64'h1);
        check("R11 chained slot", 64'(slot_o), 64'd5);
        check("R11 chained latency", 64'(cnt), 64'd8);
        check("R4 large flag", 64'(cmp_word_o[2]), 64'h1);

        // R5: tag differing in one compared bit does not match
        va = 64'h0000_0321_8000_0000;
        h = ref_hash(va, 12);
        clear_mem();
        mem[midx(int'(h & 39'h7), 0, 0)] = (ref_tag(va, 0, 0) | 64'h1) ^ 64'h0000_0000_0000_8000;
        run(va, 12, 0, 0, -1, cnt);
        check("R5 one-bit miss", 64'(hit_o), 64'h0);
        check("R4 small flag", 64'(cmp_word_o[2]), 64'h0);

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule